// File: doc/BRIEF.md
# Multiplexed Serial ADC Host Sequencer

This block is the host side of a link to a 24-bit serial delta-sigma converter that takes its master clock from the host. The block generates that clock (which also shifts the data out), holds the chip select active, and watches the data line. When the data line goes low, a new word is ready, and the block shifts the word in on rising clock edges. It also steers an external analog multiplexer through a set of channels. The aim is to get as many settled samples per second as possible.

The multiplexer is advanced at a fixed count of converter clock cycles after each ready edge. This point lies just before the end of the conversion that is in progress. The word that arrives next still belongs to the old channel, and the block keeps it. The three words after that are still settling, and the block drops them. The word after those is the first good result for the new channel. When the block starts up, it cannot know where in a conversion the multiplexer was set, so it drops the first few words. Each forwarded word comes out as a one-cycle strobe carrying the channel index, the data field sign-extended to 20 bits, the overrange flag and the oscillation flag. A word whose oscillation flag is set is still forwarded, but it is marked not usable.

Top module: `madc_host`

## Requirements
- R1: While reset is active, `cs_n` is 1 and `sclk` is 0. After reset, `cs_n` goes to 0 and stays there. The first rising edge of `sclk` comes no sooner than `CS_SETUP` clock cycles after `cs_n` falls.
- R2: Once running, `sclk` has a period of exactly 2*`HALF` clock cycles. `sdo` is sampled in the clock cycle in which `sclk` rises.
- R3: When `sdo` is sampled low while no word is being read, that sample is word bit 23. The next 23 rising edges capture bits 22 down to 0, MSB first.
- R4: `mux_sel` changes only on the `SWITCH_AT`-th `sclk` rise after the rise on which `sdo` fell. Counted the other way, this is `SWITCH_AT`-1 rises after the rise that sampled it low. It happens only in a conversion whose word was the first settled word of a channel.
- R5: `mux_sel` steps from k to k+1 and wraps from `NCH`-1 to 0. It starts at 0 after reset.
- R6: The first `STARTUP` words after reset (5 by default) are never forwarded.
- R7: After start-up, words repeat in groups of five per channel. The first word of a group is the first settled word on the current channel, and the second is the word converted just before the switch. Both carry the channel in use when the group began. The other three words are dropped.
- R8: Word bit 22 appears as `out_ovr` and word bit 21 appears as `out_osc`. A word with bit 21 set is still strobed, with `out_ok` = 0. Otherwise `out_ok` = 1.
- R9: The data field is word bits 19 down to 20-`DW`. It is sign-extended into `out_data`. Word bit 20, and the low bits below the field when `DW` = 16, have no effect.
- R10: `out_valid` is high for exactly one clock cycle per forwarded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdo | input | 1 | Serial data and ready line from the converter |
| sclk | output | 1 | Converter master clock and shift clock |
| cs_n | output | 1 | Active-low chip select |
| mux_sel | output | $clog2(NCH) | Channel applied to the analog multiplexer |
| out_valid | output | 1 | One-cycle strobe for a forwarded word |
| out_ch | output | $clog2(NCH) | Channel the word belongs to |
| out_data | output | 20 | Sign-extended conversion data |
| out_ovr | output | 1 | Overrange flag (word bit 22) |
| out_osc | output | 1 | Oscillation flag (word bit 21) |
| out_ok | output | 1 | High when the data can be used |

## Verification
A behavioural converter in the bench produces a ready edge every 612 clock rises and a different word for each conversion index. The words include the most negative and most positive 20-bit codes, a zero field with bit 20 and the low nibble set, and flag bits placed so that both forwarded positions of a group see each flag both set and clear. Two instances, one 20-bit and one 16-bit, read the same line, which separates field position and sign extension from the capture itself. Over several laps of a three-channel rotation, the bench checks the cycle of each multiplexer step, its wrap, the group it falls in, and the exact order of forwarded words with their tags. From that order it tells apart start-up drops, the kept old-channel word, and the three settling drops.

// File: rtl/madc_pkg.sv
package madc_pkg;
  localparam int WORD_BITS = 24;
  localparam int OUT_W     = 20;
  localparam int OVR_POS   = 22;
  localparam int OSC_POS   = 21;
  localparam int GROUP_LEN = 5;

  // pull the data field [19 : 20-dw] out of a word and sign-extend it
  function automatic logic [OUT_W-1:0] madc_field(input logic [WORD_BITS-1:0] w,
                                                  input int dw);
    logic [OUT_W-1:0] r;
    for (int i = 0; i < OUT_W; i++) begin
      int src;
      src  = i + (OUT_W - dw);
      r[i] = (src < OUT_W) ? w[src] : w[OUT_W-1];
    end
    return r;
  endfunction

  function automatic int madc_wrap(input int cur, input int n);
    return (cur >= n - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/madc_clkgen.sv
module madc_clkgen #(
  parameter int HALF     = 4,
  parameter int CS_SETUP = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic cs_n,
  output logic rise_evt
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int SW = $clog2(CS_SETUP + 1);

  logic          run;
  logic [PW-1:0] ph;
  logic [SW-1:0] wcnt;
  logic          edge_due;

  assign edge_due = run && (ph == PW'(HALF - 1));
  assign rise_evt = edge_due && !sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n <= 1'b1;
      sclk <= 1'b0;
      run  <= 1'b0;
      ph   <= '0;
      wcnt <= '0;
    end else begin
      cs_n <= 1'b0;
      if (!run) begin
        if (!cs_n) begin
          if (wcnt == SW'(CS_SETUP - 1)) run <= 1'b1;
          else wcnt <= wcnt + 1'b1;
        end
      end else if (edge_due) begin
        ph   <= '0;
        sclk <= ~sclk;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/madc_rx.sv
module madc_rx
  import madc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_evt,
  input  logic                 sdo,
  output logic                 ready_evt,
  output logic                 word_done,
  output logic [WORD_BITS-1:0] word
);
  localparam int BW = $clog2(WORD_BITS);

  logic          busy;
  logic [BW-1:0] bcnt;

  assign ready_evt = rise_evt && !busy && !sdo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bcnt      <= '0;
      word      <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (ready_evt) begin
        word <= {word[WORD_BITS-2:0], sdo};
        bcnt <= BW'(1);
        busy <= 1'b1;
      end else if (rise_evt && busy) begin
        word <= {word[WORD_BITS-2:0], sdo};
        if (bcnt == BW'(WORD_BITS - 1)) begin
          busy      <= 1'b0;
          word_done <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/madc_seq.sv
module madc_seq
  import madc_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int SWITCH_AT = 595,
  parameter int STARTUP   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rise_evt,
  input  logic                    ready_evt,
  output logic [$clog2(NCH)-1:0]  mux_sel,
  output logic                    switch_evt,
  output logic                    word_keep,
  output logic [$clog2(NCH)-1:0]  word_ch
);
  localparam int CW  = $clog2(NCH);
  localparam int TW  = $clog2(SWITCH_AT + 1);
  localparam int STW = $clog2(STARTUP + 1);

  logic [TW-1:0]  swcnt;
  logic [STW-1:0] stc;
  logic [2:0]     ph;
  logic           armed;

  assign switch_evt = rise_evt && armed && (swcnt == TW'(SWITCH_AT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swcnt     <= TW'(SWITCH_AT);
      stc       <= '0;
      ph        <= '0;
      armed     <= 1'b0;
      mux_sel   <= '0;
      word_keep <= 1'b0;
      word_ch   <= '0;
    end else begin
      if (switch_evt) begin
        mux_sel <= CW'(madc_wrap(int'(mux_sel), NCH));
        armed   <= 1'b0;
      end
      if (ready_evt) begin
        swcnt <= TW'(1);
        if (stc != STW'(STARTUP)) begin
          stc       <= stc + 1'b1;
          word_keep <= 1'b0;
        end else begin
          word_keep <= (ph < 3'd2);
          if (ph == 3'd0) begin
            word_ch <= mux_sel;
            armed   <= 1'b1;
          end
          ph <= (ph == 3'(GROUP_LEN - 1)) ? 3'd0 : ph + 3'd1;
        end
      end else if (rise_evt && swcnt != TW'(SWITCH_AT)) begin
        swcnt <= swcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/madc_host.sv
module madc_host
  import madc_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int DW        = 20,
  parameter int HALF      = 4,
  parameter int CS_SETUP  = 20,
  parameter int SWITCH_AT = 595,
  parameter int STARTUP   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sdo,
  output logic                   sclk,
  output logic                   cs_n,
  output logic [$clog2(NCH)-1:0] mux_sel,
  output logic                   out_valid,
  output logic [$clog2(NCH)-1:0] out_ch,
  output logic [19:0]            out_data,
  output logic                   out_ovr,
  output logic                   out_osc,
  output logic                   out_ok
);
  localparam int CW = $clog2(NCH);

  logic                 rise_evt;
  logic                 ready_evt;
  logic                 word_done;
  logic                 switch_evt;
  logic                 word_keep;
  logic [CW-1:0]        word_ch;
  logic [WORD_BITS-1:0] word;

  madc_clkgen #(.HALF(HALF), .CS_SETUP(CS_SETUP)) u_clk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .rise_evt(rise_evt)
  );

  madc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .sdo(sdo),
    .ready_evt(ready_evt), .word_done(word_done), .word(word)
  );

  madc_seq #(.NCH(NCH), .SWITCH_AT(SWITCH_AT), .STARTUP(STARTUP)) u_seq (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .ready_evt(ready_evt),
    .mux_sel(mux_sel), .switch_evt(switch_evt), .word_keep(word_keep),
    .word_ch(word_ch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
      out_ovr   <= 1'b0;
      out_osc   <= 1'b0;
      out_ok    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (word_done && word_keep) begin
        out_valid <= 1'b1;
        out_ch    <= word_ch;
        out_data  <= madc_field(word, DW);
        out_ovr   <= word[OVR_POS];
        out_osc   <= word[OSC_POS];
        out_ok    <= !word[OSC_POS];
      end
    end
  end
endmodule

// File: rtl/madc_host_chk.sv
module madc_host_chk #(
  parameter int NCH       = 4,
  parameter int DW        = 20,
  parameter int SWITCH_AT = 595
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sclk,
  input logic                   cs_n,
  input logic [$clog2(NCH)-1:0] mux_sel,
  input logic                   out_valid,
  input logic [$clog2(NCH)-1:0] out_ch,
  input logic [19:0]            out_data,
  input logic                   out_osc,
  input logic                   out_ok,
  input logic                   rise_evt,
  input logic                   ready_evt,
  input logic                   switch_evt
);
  localparam int TW = $clog2(SWITCH_AT + 1);
  localparam int CW = $clog2(NCH);

  logic [TW-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n) gap <= TW'(SWITCH_AT);
    else if (ready_evt) gap <= TW'(1);
    else if (rise_evt && gap != TW'(SWITCH_AT)) gap <= gap + 1'b1;
  end

  p_cs_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> !cs_n);
  p_rise_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);
  p_switch_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    switch_evt |-> gap == TW'(SWITCH_AT - 1));
  p_mux_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel != $past(mux_sel)) |-> $past(switch_evt));
  p_mux_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel != $past(mux_sel)) |->
      (mux_sel == (($past(mux_sel) == CW'(NCH - 1)) ? '0 : $past(mux_sel) + 1'b1)));
  p_ch_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mux_sel) < NCH);
  p_tag_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_ch) < NCH);
  p_osc_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ok == !out_osc));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  generate
    if (DW < 20) begin : g_sext
      p_sext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((&out_data[19:DW-1]) || !(|out_data[19:DW-1])));
    end
  endgenerate
endmodule

bind madc_host madc_host_chk #(.NCH(NCH), .DW(DW), .SWITCH_AT(SWITCH_AT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mux_sel(mux_sel),
  .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data),
  .out_osc(out_osc), .out_ok(out_ok), .rise_evt(rise_evt),
  .ready_evt(ready_evt), .switch_evt(switch_evt)
);

// File: tb/sim_madc_host.sv
module sim_madc_host;
  localparam int NCH      = 3;
  localparam int HALF     = 2;
  localparam int CS_SETUP = 20;
  localparam int SW_AT    = 595;
  localparam int CONV     = 612;
  localparam int OFFS     = 50;
  localparam int NW       = 37;
  localparam int NSTROBE  = 14;
  localparam int NSWITCH  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdo = 1'b1;

  logic       sclk0, cs0, v0, ovr0, osc0, ok0;
  logic [1:0] mux0, ch0;
  logic [19:0] d0;
  logic       sclk1, cs1, v1, ovr1, osc1, ok1;
  logic [1:0] mux1, ch1;
  logic [19:0] d1;

  always #5 clk = ~clk;

  madc_host #(.NCH(NCH), .DW(20), .HALF(HALF), .CS_SETUP(CS_SETUP),
              .SWITCH_AT(SW_AT), .STARTUP(5)) u0 (
    .clk(clk), .rst_n(rst_n), .sdo(sdo), .sclk(sclk0), .cs_n(cs0),
    .mux_sel(mux0), .out_valid(v0), .out_ch(ch0), .out_data(d0),
    .out_ovr(ovr0), .out_osc(osc0), .out_ok(ok0));

  madc_host #(.NCH(NCH), .DW(16), .HALF(HALF), .CS_SETUP(CS_SETUP),
              .SWITCH_AT(SW_AT), .STARTUP(5)) u1 (
    .clk(clk), .rst_n(rst_n), .sdo(sdo), .sclk(sclk1), .cs_n(cs1),
    .mux_sel(mux1), .out_valid(v1), .out_ch(ch1), .out_data(d1),
    .out_ovr(ovr1), .out_osc(osc1), .out_ok(ok1));

  int checks = 0;
  int fails = 0;
  int rc = 0;
  int nw = 0;
  int last_rdy = -100000;
  int st = 0;
  int bi = 0;
  int nsw = 0;
  int nstr = 0;
  logic [1:0] pm = 2'd0;
  logic [23:0] cw;
  logic prev_v = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [23:0] gen_word(input int n);
    logic [19:0] f;
    logic b20, ovr, osc;
    case (n)
      5:  f = 20'h80000;
      6:  f = 20'h7FFFF;
      10: f = 20'h0000F;
      default: f = 20'((n * 40503 + 4660) % 1048576);
    endcase
    b20 = (n % 2 == 1) || (n == 10);
    ovr = (n % 3 == 2);
    osc = (n % 4 == 1);
    return {1'b0, ovr, osc, b20, f};
  endfunction

  // converter model: ready every CONV rises, bits change on falls
  initial begin
    forever begin
      @(sclk0);
      if (sclk0 === 1'b1) begin
        rc++;
        if (nw < NW && rc >= OFFS && (rc - OFFS) % CONV == 0) begin
          cw = gen_word(nw);
          last_rdy = rc;
          nw++;
          sdo = 1'b0;
          st = 1;
          bi = 23;
        end
      end else if (sclk0 === 1'b0) begin
        if (st == 1) st = 2;
        else if (st == 2) begin
          if (bi > 0) begin
            bi--;
            sdo = cw[bi];
          end else begin
            sdo = 1'b1;
            st = 0;
          end
        end
        if (rst_n && mux0 != pm) begin
          chk(rc - last_rdy == SW_AT, "R4", "switch rise offset", rc - last_rdy, SW_AT);
          chk(int'(mux0) == (int'(pm) + 1) % NCH, "R5", "channel step", mux0, (int'(pm) + 1) % NCH);
          chk(nw - 1 >= 5 && (nw - 1 - 5) % 5 == 0, "R7", "switch group word", nw - 1, 5);
          nsw++;
          pm = mux0;
        end
      end
    end
  end

  // output strobe monitor
  initial begin
    forever begin
      @(negedge clk);
      if (prev_v) chk(!v0, "R10", "strobe width", v0, 0);
      if (rst_n && v0) begin
        if (nstr >= NSTROBE) begin
          chk(0, "R7", "extra strobe", nstr, NSTROBE);
        end else begin
          int g, n, e16;
          logic [23:0] w;
          g = nstr / 2;
          n = 5 + 5 * g + nstr % 2;
          w = gen_word(n);
          e16 = int'(w[19:4]);
          if (e16 >= 32768) e16 -= 65536;
          e16 = e16 & 'hFFFFF;
          chk(int'(ch0) == g % NCH, "R7", "channel tag", ch0, g % NCH);
          chk(d0 == w[19:0], (nstr == 0) ? "R6" : "R3", "data 20-bit", d0, w[19:0]);
          chk(v1 && int'(d1) == e16, "R9", "data 16-bit", d1, e16);
          chk(ovr0 == w[22] && osc0 == w[21], "R8", "flags", {ovr0, osc0}, w[22:21]);
          chk(ok0 == !w[21], "R8", "usable mark", ok0, !w[21]);
        end
        nstr++;
      end
      prev_v = v0;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int cyc, p;
    repeat (5) @(negedge clk);
    chk(cs0 == 1'b1, "R1", "cs_n in reset", cs0, 1);
    chk(sclk0 == 1'b0, "R1", "sclk in reset", sclk0, 0);
    chk(v0 == 1'b0, "R10", "strobe in reset", v0, 0);
    chk(mux0 == 2'd0, "R5", "channel in reset", mux0, 0);
    rst_n = 1'b1;
    while (cs0) @(negedge clk);
    cyc = 0;
    while (!sclk0) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc >= CS_SETUP, "R1", "cs_n to first rise", cyc, CS_SETUP);
    p = 0;
    while (sclk0) begin
      @(negedge clk);
      p++;
    end
    while (!sclk0) begin
      @(negedge clk);
      p++;
    end
    chk(p == 2 * HALF, "R2", "sclk period", p, 2 * HALF);
    chk(cs0 == 1'b0, "R1", "cs_n held", cs0, 0);
    while (!(nw == NW && st == 0)) @(negedge clk);
    repeat (200) @(negedge clk);
    chk(nstr == NSTROBE, "R6", "forwarded words", nstr, NSTROBE);
    chk(nsw == NSWITCH, "R4", "switch count", nsw, NSWITCH);
    chk(int'(mux0) == NSWITCH % NCH, "R5", "final channel", mux0, NSWITCH % NCH);
    finish_run();
  end
endmodule